// File: doc/BRIEF.md
# Multi-level tag table walker

This block fetches the security tag for one virtual address after the L1 tag cache has missed. The tags live in memory in a five-level tree of 4 KB subtables, each on a 4 KB boundary. The block starts from a root pointer and follows one entry per level. Each memory read goes through a simple request/response port that moves one 64-bit word.

The walk can stop at any level. An entry whose next-level pointer is null carries the tag for the whole region beneath it, and the block returns that tag as a uniform value. At level 4, a per-line bitmap bit can report that the addressed tag line is all one value, so the leaf is not read. If neither shortcut applies, the block reads the full 64-byte tag line from the leaf subtable and returns it for refill.

The block serves one miss at a time. The response either names a uniform tag, with a flag telling the cache to fill the line with it, or carries the whole line. It also reports the level at which the walk ended.

Top module: `tag_table_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `rsp_valid` and `mem_req_valid` are 0.
- R2: The virtual address is split as follows: bits [47:39] index level 1, [38:30] index level 2, [29:21] index level 3, [20:13] index level 4, [12:7] pick the tag line, and [6:0] are not used. Bits [63:48] are also ignored. The first read of a walk is at `{root_ptr, 12'h000} + 8*va[47:39]`.
- R3: An entry at levels 1 to 3 is a 64-bit word. Bits [63:12] are the next-level page number and bits [3:0] are the tag. If the page number is zero, the walk ends with `rsp_uniform`=1, `rsp_tag` equal to the entry's bits [3:0], and `rsp_level` equal to that level.
- R4: If the page number of an entry at levels 1 to 3 is non-zero, its tag bits are ignored. The next read is at `{page, 12'h000} + 8*index` of the next level.
- R5: A level-4 entry takes 16 bytes at `{page,12'h000} + 16*va[20:13]`. Its pointer/tag word sits at offset +8 and is read first. If that pointer is null, the walk ends uniform at level 4 after exactly four reads.
- R6: If the level-4 pointer is non-null, the bitmap word at offset +0 is read next. If bit `va[12:7]` of that word is 1, the walk ends uniform at level 4 with the level-4 entry's tag. No leaf read is made, so the walk takes five reads.
- R7: If that bitmap bit is 0, the block reads eight words at `{leaf_page,12'h000} + 64*va[12:7] + 8*k` for k = 0 to 7. Word k goes to `rsp_line[64k+63:64k]`. The response then has `rsp_uniform`=0, `rsp_level`=5 and `rsp_tag`=0.
- R8: `req_ready` is high only while idle. `busy` rises after a request is accepted and stays high until the cycle after the response handshake.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, every response output holds its value.
- R10: A memory request holds its address until it is accepted. A uniform response returns an all-zero `rsp_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address of the miss |
| root_ptr | input | 52 | Page number of the level-1 subtable |
| busy | output | 1 | A walk or its response is in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Physical byte address of the 64-bit word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data |
| rsp_valid | output | 1 | Refill response present |
| rsp_ready | input | 1 | Cache takes the response |
| rsp_uniform | output | 1 | Fill the whole line with `rsp_tag` |
| rsp_tag | output | 4 | Uniform tag value |
| rsp_level | output | 3 | Level (1 to 5) at which the walk ended |
| rsp_line | output | 512 | Tag line read from the leaf |

## Verification
The assertions rely on the memory side returning exactly one `mem_rsp_valid` pulse per accepted request, and only after that request. They also rely on `req_vaddr` and `root_ptr` being valid in the cycle of acceptance. The bench's memory model meets both conditions: it holds a single pending read and answers it two cycles after acceptance. Its `mem_req_ready` toggles every cycle, so requests regularly wait while held. The table image is sparse, and missing words read as zero, so an absent entry acts as a null pointer.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } tw_state_e;

    localparam logic [2:0] LVL_ROOT = 3'd1;
    localparam logic [2:0] LVL_EXT  = 3'd4;
    localparam logic [2:0] LVL_LEAF = 3'd5;
endpackage

// File: rtl/tw_addr.sv
module tw_addr #(
    parameter int PA_W      = 64,
    parameter int PG_BITS   = 12,
    parameter int DIR_IDX_W = 9,
    parameter int L4_IDX_W  = 8,
    parameter int SEL_W     = 6,
    parameter int BEAT_W    = 64,
    parameter int LINE_W    = 512,
    localparam int PTR_W    = PA_W - PG_BITS,
    localparam int FLD_W    = 3 * DIR_IDX_W + L4_IDX_W + SEL_W,
    localparam int STEP_W   = $clog2(LINE_W / BEAT_W)
) (
    input  logic [2:0]        level_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [PTR_W-1:0]  base_i,
    input  logic [FLD_W-1:0]  fld_i,
    output logic [PA_W-1:0]   addr_o
);
    localparam int WORD_SH = $clog2(BEAT_W / 8);
    localparam int EXT_SH  = WORD_SH + 1;
    localparam int LINE_SH = $clog2(LINE_W / 8);
    localparam int L4_LO   = SEL_W;
    localparam int L3_LO   = L4_LO + L4_IDX_W;
    localparam int L2_LO   = L3_LO + DIR_IDX_W;
    localparam int L1_LO   = L2_LO + DIR_IDX_W;

    logic [PA_W-1:0] page;
    logic [PA_W-1:0] off;

    assign page = {base_i, {PG_BITS{1'b0}}};

    always_comb begin
        case (level_i)
            3'd1:    off = PA_W'(fld_i[L1_LO +: DIR_IDX_W]) << WORD_SH;
            3'd2:    off = PA_W'(fld_i[L2_LO +: DIR_IDX_W]) << WORD_SH;
            3'd3:    off = PA_W'(fld_i[L3_LO +: DIR_IDX_W]) << WORD_SH;
            3'd4:    off = (PA_W'(fld_i[L4_LO +: L4_IDX_W]) << EXT_SH)
                         + ((step_i == '0) ? PA_W'(BEAT_W / 8) : PA_W'(0));
            default: off = (PA_W'(fld_i[0 +: SEL_W]) << LINE_SH)
                         + (PA_W'(step_i) << WORD_SH);
        endcase
    end

    assign addr_o = page + off;
endmodule

// File: rtl/tw_linebuf.sv
module tw_linebuf #(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 8,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    wr_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [BEAT_W-1:0]       data_i,
    output logic [BEATS*BEAT_W-1:0] line_o
);
    for (genvar g = 0; g < BEATS; g++) begin : g_beat
        logic [BEAT_W-1:0] beat_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                beat_q <= '0;
            else if (clr_i)
                beat_q <= '0;
            else if (wr_i && idx_i == IDX_W'(g))
                beat_q <= data_i;
        end
        assign line_o[g*BEAT_W +: BEAT_W] = beat_q;
    end
endmodule

// File: rtl/tag_table_walker.sv
module tag_table_walker
    import tw_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 64,
    parameter int PG_BITS   = 12,
    parameter int TAG_W     = 4,
    parameter int DIR_IDX_W = 9,
    parameter int L4_IDX_W  = 8,
    parameter int SEL_W     = 6,
    parameter int OFF_W     = 7,
    parameter int BEAT_W    = 64,
    parameter int LINE_W    = 512,
    localparam int PTR_W    = PA_W - PG_BITS,
    localparam int FLD_W    = 3 * DIR_IDX_W + L4_IDX_W + SEL_W,
    localparam int TOP_BIT  = OFF_W + FLD_W - 1,
    localparam int BEATS    = LINE_W / BEAT_W,
    localparam int STEP_W   = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PTR_W-1:0]  root_ptr,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [BEAT_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_uniform,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [2:0]        rsp_level,
    output logic [LINE_W-1:0] rsp_line
);
    typedef struct packed {
        tw_state_e         st;
        logic [2:0]        level;
        logic [STEP_W-1:0] step;
        logic [PTR_W-1:0]  base;
        logic [PTR_W-1:0]  nxt;
        logic [TAG_W-1:0]  tag;
        logic              uniform;
        logic [FLD_W-1:0]  fld;
    } walk_t;

    walk_t q, d;
    logic clr_line, wr_line;
    logic [PTR_W-1:0] ent_ptr;
    logic [TAG_W-1:0] ent_tag;
    logic unused_va;

    assign unused_va = ^{req_vaddr[VA_W-1:TOP_BIT+1], req_vaddr[OFF_W-1:0]};
    assign ent_ptr   = mem_rsp_data[BEAT_W-1 -: PTR_W];
    assign ent_tag   = mem_rsp_data[TAG_W-1:0];

    always_comb begin
        d        = q;
        clr_line = 1'b0;
        wr_line  = 1'b0;
        case (q.st)
            ST_IDLE: if (req_valid) begin
                d.st      = ST_REQ;
                d.level   = LVL_ROOT;
                d.step    = '0;
                d.base    = root_ptr;
                d.nxt     = '0;
                d.tag     = '0;
                d.uniform = 1'b0;
                d.fld     = req_vaddr[TOP_BIT:OFF_W];
                clr_line  = 1'b1;
            end
            ST_REQ: if (mem_req_ready) d.st = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
                if (q.level == LVL_LEAF) begin
                    wr_line = 1'b1;
                    if (q.step == STEP_W'(BEATS - 1)) begin
                        d.st = ST_DONE;
                    end else begin
                        d.step = q.step + 1'b1;
                        d.st   = ST_REQ;
                    end
                end else if (q.level == LVL_EXT && q.step != '0) begin
                    if (mem_rsp_data[q.fld[SEL_W-1:0]]) begin
                        d.uniform = 1'b1;
                        d.st      = ST_DONE;
                    end else begin
                        d.level = LVL_LEAF;
                        d.step  = '0;
                        d.base  = q.nxt;
                        d.tag   = '0;
                        d.st    = ST_REQ;
                    end
                end else if (ent_ptr == '0) begin
                    d.uniform = 1'b1;
                    d.tag     = ent_tag;
                    d.st      = ST_DONE;
                end else if (q.level == LVL_EXT) begin
                    d.nxt  = ent_ptr;
                    d.tag  = ent_tag;
                    d.step = STEP_W'(1);
                    d.st   = ST_REQ;
                end else begin
                    d.base  = ent_ptr;
                    d.level = q.level + 3'd1;
                    d.st    = ST_REQ;
                end
            end
            default: if (rsp_ready) d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    tw_addr #(
        .PA_W(PA_W), .PG_BITS(PG_BITS), .DIR_IDX_W(DIR_IDX_W),
        .L4_IDX_W(L4_IDX_W), .SEL_W(SEL_W), .BEAT_W(BEAT_W), .LINE_W(LINE_W)
    ) u_addr (
        .level_i(q.level), .step_i(q.step), .base_i(q.base),
        .fld_i(q.fld), .addr_o(mem_req_addr)
    );

    tw_linebuf #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_line (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_line), .wr_i(wr_line),
        .idx_i(q.step), .data_i(mem_rsp_data), .line_o(rsp_line)
    );

    assign req_ready     = (q.st == ST_IDLE);
    assign busy          = (q.st != ST_IDLE);
    assign mem_req_valid = (q.st == ST_REQ);
    assign rsp_valid     = (q.st == ST_DONE);
    assign rsp_uniform   = q.uniform;
    assign rsp_tag       = q.tag;
    assign rsp_level     = q.level;

    assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_req_valid &&
        mem_req_addr == {$past(root_ptr), {PG_BITS{1'b0}}}
                      + (PA_W'($past(req_vaddr[TOP_BIT -: DIR_IDX_W])) << 3));

    assert_uniform_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_uniform) |-> (rsp_level >= 3'd1 && rsp_level <= 3'd4));

    assert_line_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_uniform) |-> (rsp_level == 3'd5 && rsp_tag == '0));

    assert_busy_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy && !req_ready);

    assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> !busy);

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_line) &&
        $stable(rsp_tag) && $stable(rsp_uniform) && $stable(rsp_level));

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

    assert_uniform_zero_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_uniform) |-> rsp_line == '0);
endmodule

// File: tb/sim_tag_table_walker.sv
`timescale 1ns/1ps
module sim_tag_table_walker;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [63:0]  req_vaddr = '0;
    logic [51:0]  root_ptr = 52'h100;
    logic         busy;
    logic         mem_req_valid;
    logic         mem_req_ready;
    logic [63:0]  mem_req_addr;
    logic         mem_rsp_valid;
    logic [63:0]  mem_rsp_data;
    logic         rsp_valid;
    logic         rsp_ready = 1'b0;
    logic         rsp_uniform;
    logic [3:0]   rsp_tag;
    logic [2:0]   rsp_level;
    logic [511:0] rsp_line;

    logic [63:0] mem [logic [63:0]];
    logic        pend;
    logic [63:0] paddr;
    int          nreads;
    logic [63:0] alog [0:15];
    logic        clr_log = 1'b0;

    int checks = 0;
    int errors = 0;
    logic         r_uni;
    logic [3:0]   r_tag;
    logic [2:0]   r_lvl;
    logic [511:0] r_line;

    always #10 clk = ~clk;

    tag_table_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_ptr(root_ptr), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_uniform(rsp_uniform), .rsp_tag(rsp_tag), .rsp_level(rsp_level),
        .rsp_line(rsp_line)
    );

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            pend          <= 1'b0;
            paddr         <= '0;
            nreads        <= 0;
        end else begin
            mem_req_ready <= ~mem_req_ready;
            mem_rsp_valid <= 1'b0;
            if (clr_log) nreads <= 0;
            if (mem_req_valid && mem_req_ready) begin
                pend  <= 1'b1;
                paddr <= mem_req_addr;
                alog[nreads % 16] <= mem_req_addr;
                if (!clr_log) nreads <= nreads + 1;
            end else if (pend) begin
                pend          <= 1'b0;
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(paddr);
            end
        end
    end

    function automatic logic [63:0] pg(input logic [51:0] p);
        return {p, 12'h000};
    endfunction

    function automatic logic [63:0] mkva(input int i1, i2, i3, i4, sel);
        return (64'hABCD << 48) | (64'(i1) << 39) | (64'(i2) << 30) |
               (64'(i3) << 21) | (64'(i4) << 13) | (64'(sel) << 7) | 64'h15;
    endfunction

    function automatic logic [63:0] pat(input int k);
        return {32'hFACE0000 | 32'(k), 32'h12345678 ^ 32'(k * 7)};
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic walk(input logic [63:0] va, input int hold);
        int t;
        @(negedge clk);
        chk("R8 idle before request", {63'd0, req_ready}, 64'd1);
        req_vaddr = va;
        req_valid = 1'b1;
        clr_log   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        clr_log   = 1'b0;
        chk("R8 busy after accept", {63'd0, busy}, 64'd1);
        t = 0;
        while (!rsp_valid && t < 300) begin
            @(negedge clk);
            t++;
        end
        chk("R8 response arrives", {63'd0, rsp_valid}, 64'd1);
        r_uni = rsp_uniform; r_tag = rsp_tag; r_lvl = rsp_level; r_line = rsp_line;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R9 hold valid", {63'd0, rsp_valid}, 64'd1);
            chk("R9 hold fields", {56'd0, rsp_uniform, rsp_tag, rsp_level},
                {56'd0, r_uni, r_tag, r_lvl});
            chk("R9 hold line", {63'd0, rsp_line == r_line}, 64'd1);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R8 busy released", {62'd0, busy, rsp_valid}, 64'd0);
    endtask

    task automatic check_uniform(input string rq, input logic [3:0] tag,
                                 input logic [2:0] lvl, input int reads);
        chk({rq, " uniform flag"}, {63'd0, r_uni}, 64'd1);
        chk({rq, " tag"}, {60'd0, r_tag}, {60'd0, tag});
        chk({rq, " level"}, {61'd0, r_lvl}, {61'd0, lvl});
        chk({rq, " read count"}, 64'(nreads), 64'(reads));
        chk("R10 zero line on uniform", {63'd0, r_line == '0}, 64'd1);
    endtask

    task automatic t_reset();
        chk("R1 req_ready", {63'd0, req_ready}, 64'd1);
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    endtask

    task automatic t_level1();
        walk(mkva(3, 0, 0, 0, 0), 0);
        check_uniform("R3 level1", 4'h5, 3'd1, 1);
        chk("R2 first address", alog[0], pg(52'h100) + 64'(3 * 8));
        walk(mkva(7, 1, 1, 1, 1), 0);
        check_uniform("R3 absent entry", 4'h0, 3'd1, 1);
    endtask

    task automatic t_level2_3();
        walk(mkva(1, 4, 0, 0, 0), 0);
        check_uniform("R3 level2 R4 tag ignored", 4'h6, 3'd2, 2);
        chk("R4 second address", alog[1], pg(52'h200) + 64'(4 * 8));
        walk(mkva(1, 5, 2, 0, 0), 0);
        check_uniform("R3 level3", 4'h9, 3'd3, 3);
        chk("R4 third address", alog[2], pg(52'h300) + 64'(2 * 8));
    endtask

    task automatic t_level4();
        walk(mkva(1, 5, 7, 10, 0), 0);
        check_uniform("R5 level4 null", 4'hC, 3'd4, 4);
        chk("R5 pointer word address", alog[3], pg(52'h400) + 64'(10 * 16 + 8));
        walk(mkva(1, 5, 7, 11, 20), 0);
        check_uniform("R6 bitmap hit", 4'h3, 3'd4, 5);
        chk("R6 bitmap address", alog[4], pg(52'h400) + 64'(11 * 16));
    endtask

    task automatic t_leaf();
        walk(mkva(1, 5, 7, 11, 21), 0);
        chk("R7 uniform flag", {63'd0, r_uni}, 64'd0);
        chk("R7 level", {61'd0, r_lvl}, 64'd5);
        chk("R7 tag", {60'd0, r_tag}, 64'd0);
        chk("R7 read count", 64'(nreads), 64'd13);
        chk("R7 first leaf address", alog[5], pg(52'h500) + 64'(21 * 64));
        chk("R7 last leaf address", alog[12], pg(52'h500) + 64'(21 * 64 + 56));
        for (int k = 0; k < 8; k++)
            chk("R7 line beat", r_line[64*k +: 64], pat(k));
    endtask

    task automatic t_backpressure();
        walk(mkva(1, 5, 7, 11, 30), 5);
        chk("R7 held line beat 3", r_line[192 +: 64], pat(100 + 3));
        walk(mkva(1, 5, 7, 10, 0), 4);
        check_uniform("R9 held uniform", 4'hC, 3'd4, 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        mem[pg(52'h100) + 3 * 8]        = 64'h0000_0000_0000_0005;
        mem[pg(52'h100) + 1 * 8]        = {52'h200, 12'h00A};
        mem[pg(52'h200) + 4 * 8]        = 64'h6;
        mem[pg(52'h200) + 5 * 8]        = {52'h300, 12'h000};
        mem[pg(52'h300) + 2 * 8]        = 64'h9;
        mem[pg(52'h300) + 7 * 8]        = {52'h400, 12'h00F};
        mem[pg(52'h400) + 10 * 16 + 8]  = 64'hC;
        mem[pg(52'h400) + 11 * 16 + 8]  = {52'h500, 12'h003};
        mem[pg(52'h400) + 11 * 16]      = 64'h1 << 20;
        for (int k = 0; k < 8; k++) begin
            mem[pg(52'h500) + 21 * 64 + 8 * k] = pat(k);
            mem[pg(52'h500) + 30 * 64 + 8 * k] = pat(100 + k);
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level1();
        t_level2_3();
        t_level4();
        t_leaf();
        t_backpressure();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule